// File: doc/BRIEF.md
# Clock-Stop SPI Master Engine

This block moves one word at a time between a parallel interface and four SPI pins. It acts as the bus master. A request on `start` samples a divider value and a transmit word. The engine then pulls the active-low select line low and waits through one low-time interval. After that it produces one serial-clock pulse per bit. Each rising edge launches the next outgoing bit, most significant first. Each falling edge captures one incoming bit from `sdi`. Between transfers the serial clock is parked low and gives no edges at all. This makes it a clock-stop style of operation: the slave sees clock activity only while it is selected.

The serial clock is generated from the block clock. One serial period lasts the divider value plus one input cycles. The high and low phases are split by an odd/even rule. The low phase of the final bit completes, and then, in the same cycle, the select line returns high and the data output enable drops. The pad can then tri-state the line. In that cycle a one-cycle `done` pulse presents the received word. A `start` seen while the engine is busy is dropped, and changes on the divider input during a transfer have no effect.

Top module: `spi_stop_master`

## Requirements
- R1: One serial-clock period (rising edge to next rising edge, or high phase plus the following low phase) lasts DIV+1 cycles of `clk`. DIV is sampled from `div` in the cycle `start` is accepted, and a DIV of 0 is handled as DIV = 1.
- R2: For an even nonzero DIV, `sclk` stays high for DIV/2+1 cycles and low for DIV/2 cycles in each bit.
- R3: For an odd DIV, `sclk` stays high and low for (DIV+1)/2 cycles each. DIV = 0 gives one high cycle and one low cycle.
- R4: Out of reset and whenever no transfer is in progress, `sclk`=0, `sen_n`=1, `sdo_oe`=0 and `busy`=0. `sclk` is never 1 while `sen_n` is 1.
- R5: When `start` is accepted, `sen_n` falls on the next clock edge and stays low with `sclk` low for exactly one low-phase length before the first rising edge of `sclk`.
- R6: `sdo` changes only together with a rising edge of `sclk`. It carries `tx_word` from bit WORD_W-1 down to bit 0, one bit per rising edge. `sdo_oe` is 1 whenever `sclk` is high.
- R7: `sdi` is captured on the `clk` edge on which `sclk` falls. In `rx_word`, the first captured bit is bit WORD_W-1 and the last is bit 0.
- R8: A transfer has exactly WORD_W rising and WORD_W falling edges of `sclk`. After the low phase of the last bit, `sen_n` returns to 1 and `sdo_oe` to 0 in the same cycle. `sdo_oe` is never 1 while `sen_n` is 1.
- R9: `done` is high for exactly one cycle per transfer: the first cycle with `sen_n` high again. In that cycle `busy` is 0 and `rx_word` holds the received word. `rx_word` changes at no other time.
- R10: `busy` rises the cycle after `start` is accepted. A `start` pulse while busy, and any change of `div` during a transfer, change neither the running transfer nor what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transfer; accepted only when idle |
| div | input | DIV_W | Serial clock divider value, sampled at start |
| tx_word | input | WORD_W | Word to send, sampled at start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the word is complete |
| rx_word | output | WORD_W | Received word, valid while done is high |
| sclk | output | 1 | Serial clock, idles low |
| sen_n | output | 1 | Slave select, active low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the engine with WORD_W = 12 and DIV_W = 5. The 12-bit word exercises a bit counter that is not a power of two. The 5-bit divider reaches the widest settings, 30 and 31, where the high and low counts hit their full width. Between those extremes it covers DIV values 0, 1, 3, 4 and 6, so both the even and the odd split are measured with short and long phases. The same runs check the lead interval and the edge counts against the expected values.

// File: rtl/spi_stop_pkg.sv
package spi_stop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spi_div_calc.sv
// Turns a divider value into high and low phase lengths of the serial clock.
module spi_div_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] hi_len,
    output logic [DIV_W-1:0] lo_len
);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        // a zero divider cannot split one cycle in two; run it as one
        eff  = (div_val == '0) ? DIV_W'(1) : div_val;
        half = eff >> 1;
        // high phase is always the larger (or equal) half
        hi_len = half + DIV_W'(1);
        lo_len = eff[0] ? (half + DIV_W'(1)) : half;
    end

endmodule

// File: rtl/spi_ctrl.sv
// Sequencer: select lead-in, high/low phase timing, bit count.
module spi_ctrl
    import spi_stop_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_in,
    input  logic [DIV_W-1:0] hi_len,
    input  logic [DIV_W-1:0] lo_len,
    output logic [DIV_W-1:0] div_sel,
    output logic             load,
    output logic             launch,
    output logic             sample,
    output logic             finish,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             sen_n,
    output logic             oe
);

    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BW-1:0] BITS_LAST = BW'(WORD_W - 1);

    typedef struct packed {
        spi_state_e       state;
        logic [DIV_W-1:0] cnt;
        logic [BW-1:0]    bits;
        logic [DIV_W-1:0] div;
        logic             sclk;
        logic             sen_n;
        logic             oe;
        logic             done;
    } ctrl_regs_t;

    ctrl_regs_t reg_d, reg_q;

    // while idle, timing follows the live input so the lead-in can be loaded
    assign div_sel = (reg_q.state == ST_IDLE) ? div_in : reg_q.div;

    always_comb begin
        reg_d      = reg_q;
        reg_d.done = 1'b0;
        load       = 1'b0;
        launch     = 1'b0;
        sample     = 1'b0;
        finish     = 1'b0;
        unique case (reg_q.state)
            ST_IDLE: begin
                if (start) begin
                    reg_d.state = ST_LEAD;
                    reg_d.div   = div_in;
                    reg_d.cnt   = lo_len - DIV_W'(1);
                    reg_d.bits  = BITS_LAST;
                    reg_d.sen_n = 1'b0;
                    load        = 1'b1;
                end
            end
            ST_LEAD: begin
                if (reg_q.cnt == '0) begin
                    reg_d.state = ST_HIGH;
                    reg_d.sclk  = 1'b1;
                    reg_d.oe    = 1'b1;
                    reg_d.cnt   = hi_len - DIV_W'(1);
                    launch      = 1'b1;
                end else begin
                    reg_d.cnt = reg_q.cnt - DIV_W'(1);
                end
            end
            ST_HIGH: begin
                if (reg_q.cnt == '0) begin
                    reg_d.state = ST_LOW;
                    reg_d.sclk  = 1'b0;
                    reg_d.cnt   = lo_len - DIV_W'(1);
                    sample      = 1'b1;
                end else begin
                    reg_d.cnt = reg_q.cnt - DIV_W'(1);
                end
            end
            ST_LOW: begin
                if (reg_q.cnt == '0) begin
                    if (reg_q.bits == '0) begin
                        reg_d.state = ST_IDLE;
                        reg_d.sen_n = 1'b1;
                        reg_d.oe    = 1'b0;
                        reg_d.done  = 1'b1;
                        finish      = 1'b1;
                    end else begin
                        reg_d.state = ST_HIGH;
                        reg_d.bits  = reg_q.bits - BW'(1);
                        reg_d.sclk  = 1'b1;
                        reg_d.cnt   = hi_len - DIV_W'(1);
                        launch      = 1'b1;
                    end
                end else begin
                    reg_d.cnt = reg_q.cnt - DIV_W'(1);
                end
            end
            default: reg_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q       <= '0;
            reg_q.state <= ST_IDLE;
            reg_q.sen_n <= 1'b1;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign busy  = (reg_q.state != ST_IDLE);
    assign done  = reg_q.done;
    assign sclk  = reg_q.sclk;
    assign sen_n = reg_q.sen_n;
    assign oe    = reg_q.oe;

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.sen_n |-> !reg_q.sclk); // R4

    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.oe |-> !reg_q.sen_n); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.done |=> !reg_q.done); // R9

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.done |-> (reg_q.sen_n && !reg_q.oe && !busy)); // R9

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.state != ST_IDLE) |=> $stable(reg_q.div)); // R10

    AST_DUTY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.state == ST_LEAD) |->
            ((hi_len >= lo_len) && ((hi_len - lo_len) <= DIV_W'(1)))); // R3

endmodule

// File: rtl/spi_shifter.sv
// Transmit and receive shift registers plus the received-word holding register.
module spi_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              launch,
    input  logic              sample,
    input  logic              finish,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              sdi,
    output logic              sdo,
    output logic [WORD_W-1:0] rx_word
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] rx_out;
        logic              sdo;
    } shf_regs_t;

    shf_regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (load) begin
            reg_d.tx  = tx_word;
            reg_d.rx  = '0;
            reg_d.sdo = 1'b0;
        end
        if (launch) begin
            reg_d.sdo = reg_q.tx[WORD_W-1];
            reg_d.tx  = {reg_q.tx[WORD_W-2:0], 1'b0};
        end
        if (sample) begin
            reg_d.rx = {reg_q.rx[WORD_W-2:0], sdi};
        end
        if (finish) begin
            reg_d.rx_out = reg_q.rx;
            reg_d.sdo    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign sdo     = reg_q.sdo;
    assign rx_word = reg_q.rx_out;

    AST_SDO_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !load && !finish) |=> $stable(reg_q.sdo)); // R6

    AST_RX_ONLY_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(reg_q.rx_out)); // R9

endmodule

// File: rtl/spi_stop_master.sv
// Top level: SPI master with programmable serial clock divider, clock parked low between words.
module spi_stop_master #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  div,
    input  logic [WORD_W-1:0] tx_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              sen_n,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);

    logic [DIV_W-1:0] div_sel;
    logic [DIV_W-1:0] hi_len;
    logic [DIV_W-1:0] lo_len;
    logic             load, launch, sample, finish;

    spi_div_calc #(.DIV_W(DIV_W)) u_calc (
        .div_val (div_sel),
        .hi_len  (hi_len),
        .lo_len  (lo_len)
    );

    spi_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .div_in  (div),
        .hi_len  (hi_len),
        .lo_len  (lo_len),
        .div_sel (div_sel),
        .load    (load),
        .launch  (launch),
        .sample  (sample),
        .finish  (finish),
        .busy    (busy),
        .done    (done),
        .sclk    (sclk),
        .sen_n   (sen_n),
        .oe      (sdo_oe)
    );

    spi_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .launch  (launch),
        .sample  (sample),
        .finish  (finish),
        .tx_word (tx_word),
        .sdi     (sdi),
        .sdo     (sdo),
        .rx_word (rx_word)
    );

endmodule

// File: tb/sim_spi_stop_master.sv
module sim_spi_stop_master;

    localparam int WW = 12;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] div_i = '0;
    logic [WW-1:0] tx_i = '0;
    logic          busy, done, sclk, sen_n, sdo, sdo_oe;
    logic          sdi = 1'b0;
    logic [WW-1:0] rx_word;

    always #2 clk = ~clk;   // 250 MHz

    spi_stop_master #(.WORD_W(WW), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div_i), .tx_word(tx_i),
        .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk),
        .sen_n(sen_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- bus monitor and slave model ----------------
    logic [WW-1:0] slv = '0;
    logic [WW-1:0] mosi;
    logic [WW-1:0] rx_cap;
    int  lead_len, hi_min, hi_max, lo_min, lo_max, rises, falls, dones, frames;
    int  hi_run, lo_run, viol, oe_bad, done_bad;
    logic prev_sclk = 1'b0, prev_sen = 1'b1;

    task automatic mon_clear();
        mosi = '0; rx_cap = '0; lead_len = -1;
        hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
        rises = 0; falls = 0; dones = 0; frames = 0;
        hi_run = 0; lo_run = 0; viol = 0; oe_bad = 0; done_bad = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sen_n && sclk) viol++;
            if (sen_n && sdo_oe) oe_bad++;
            if (sclk && !sdo_oe) oe_bad++;
            if (done) begin
                dones++;
                rx_cap = rx_word;
                if (!sen_n || sdo_oe || busy) done_bad++;
            end
            if (prev_sen && !sen_n) begin
                frames++;
                lo_run = 1;
            end else if (!prev_sen && sen_n) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end else if (sclk && !prev_sclk) begin
                if (rises == 0) lead_len = lo_run;
                else begin
                    if (lo_run < lo_min) lo_min = lo_run;
                    if (lo_run > lo_max) lo_max = lo_run;
                end
                rises++;
                mosi = {mosi[WW-2:0], sdo};
                hi_run = 1;
            end else if (!sclk && prev_sclk) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                falls++;
                if (falls < WW) sdi = slv[WW-1-falls];
                lo_run = 1;
            end else if (!sen_n) begin
                if (sclk) hi_run++;
                else lo_run++;
            end
            prev_sclk = sclk;
            prev_sen  = sen_n;
        end
    end

    function automatic int eff_of(input int d);
        return (d == 0) ? 1 : d;
    endfunction
    function automatic int hi_of(input int d);
        return eff_of(d) / 2 + 1;
    endfunction
    function automatic int lo_of(input int d);
        return (eff_of(d) % 2 == 1) ? eff_of(d) / 2 + 1 : eff_of(d) / 2;
    endfunction

    task automatic kick(input int d, input logic [WW-1:0] tx, input logic [WW-1:0] s);
        slv = s;
        sdi = s[WW-1];
        mon_clear();
        @(negedge clk);
        div_i = DW'(d);
        tx_i  = tx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy after start", busy, 1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && dones == 0; i++) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input int d,
                               input logic [WW-1:0] tx, input logic [WW-1:0] s);
        int h, l;
        h = hi_of(d);
        l = lo_of(d);
        chk("R9", {tag, " done count"}, dones, 1);
        chk("R9", {tag, " done with select released"}, done_bad, 0);
        chk("R1", {tag, " period"}, hi_max + lo_max, eff_of(d) + 1);
        chk((eff_of(d) % 2 == 0) ? "R2" : "R3", {tag, " high min"}, hi_min, h);
        chk((eff_of(d) % 2 == 0) ? "R2" : "R3", {tag, " high max"}, hi_max, h);
        chk((eff_of(d) % 2 == 0) ? "R2" : "R3", {tag, " low min"}, lo_min, l);
        chk((eff_of(d) % 2 == 0) ? "R2" : "R3", {tag, " low max"}, lo_max, l);
        chk("R5", {tag, " lead"}, lead_len, l);
        chk("R8", {tag, " rising edges"}, rises, WW);
        chk("R8", {tag, " falling edges"}, falls, WW);
        chk("R6", {tag, " mosi word"}, mosi, tx);
        chk("R7", {tag, " rx word"}, rx_cap, s);
        chk("R4", {tag, " clock outside select"}, viol, 0);
        chk("R8", {tag, " output enable window"}, oe_bad, 0);
        chk("R4", {tag, " idle sclk"}, sclk, 0);
        chk("R4", {tag, " idle sen_n"}, sen_n, 1);
        chk("R4", {tag, " idle busy"}, busy, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R4", "reset sclk", sclk, 0);
        chk("R4", "reset sen_n", sen_n, 1);
        chk("R4", "reset sdo_oe", sdo_oe, 0);
        chk("R4", "reset busy", busy, 0);
        chk("R9", "reset done", done, 0);
    endtask

    task automatic t_xfer(input string tag, input int d,
                          input logic [WW-1:0] tx, input logic [WW-1:0] s);
        kick(d, tx, s);
        wait_done();
        @(negedge clk);
        check_frame(tag, d, tx, s);
    endtask

    task automatic t_busy_ignore();
        logic [WW-1:0] tx, s;
        tx = 12'hB3C;
        s  = 12'h4D2;
        kick(6, tx, s);
        for (int i = 0; i < 20; i++) @(negedge clk);
        div_i = DW'(1);
        tx_i  = 12'h0F0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        check_frame("R10 busy start", 6, tx, s);
        for (int i = 0; i < 40; i++) @(negedge clk);
        chk("R10", "no second frame after ignored start", frames, 1);
        chk("R10", "select still high", sen_n, 1);
    endtask

    initial begin
        mon_clear();
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_xfer("odd3",  3,  12'hA5C, 12'h3E1);
        t_xfer("even4", 4,  12'h001, 12'h800);
        t_xfer("zero",  0,  12'hFFF, 12'h000);
        t_xfer("one",   1,  12'h000, 12'hFFF);
        t_xfer("max31", 31, 12'h6B7, 12'h9C4);
        t_xfer("even30",30, 12'h924, 12'h5A5);
        t_busy_ignore();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule